// File: doc/BRIEF.md
# Processor Supervisor Reset Controller

This block produces the system reset for a processor from four causes. The causes are a supply-good flag that drops, a push-button that is held low, a watchdog strobe that stops toggling, and the block's own power-up. Every time interval is counted in millisecond tick enables that come in alongside the system clock. The block uses no local oscillator.

A loss of supply asserts reset in the same cycle, through a combinational path. The other causes start a hold window. While a cause is present the window restarts. Once every cause has gone, the window lasts `HOLD_MS` ticks and then reset releases. The watchdog timeout comes from a two-bit select that encodes a three-level pin. The push-button is accepted only after `PB_FILT_MS` ticks of continuous low level. The push-button, strobe and supply-good inputs each pass through a two-flop synchroniser. Two outputs are provided: an active-high reset, and a drive-enable for an open-drain, active-low reset pin.

Top module: `supv_reset_ctrl`

## Requirements
- R1: From the block's own reset, and while that reset is held, `rst_hi_o` is 1. After the block's reset is released with the supply good, `rst_hi_o` falls on the `HOLD_MS`-th tick.
- R2: When no strobe falling edge occurs, the watchdog asserts reset on the N-th tick after the counter was last cleared. N is `WD_SHORT_MS` for `wd_sel` = 2'b00, `WD_MID_MS` for 2'b01 and `WD_LONG_MS` for 2'b10.
- R3: `wd_sel` = 2'b11 gives the same timeout as 2'b10.
- R4: A high-to-low transition on `wd_strobe` clears the watchdog count. A rising edge, or a steady level, leaves the count running.
- R5: Falling strobe edges that arrive more often than the selected timeout keep `rst_hi_o` at 0.
- R6: A push-button low level that lasts fewer than `PB_FILT_MS` ticks has no effect on `rst_hi_o`.
- R7: A push-button low level that lasts `PB_FILT_MS` ticks asserts reset. Reset stays asserted while the button is held, and falls on the `HOLD_MS`-th tick after the button is released.
- R8: `supply_ok` = 0 drives `rst_hi_o` to 1 in the same cycle, with no clock edge needed.
- R9: After `supply_ok` returns to 1, reset falls on the `HOLD_MS`-th tick.
- R10: After a watchdog timeout, reset falls on the `HOLD_MS`-th tick. The watchdog then counts again from zero.
- R11: `rst_lo_drive_o` (1 = pull the active-low pin low, 0 = release it) always equals `rst_hi_o`.
- R12: The watchdog count is held at zero while reset is asserted, so a hold window longer than the timeout ends without a further watchdog reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| ms_tick | input | 1 | One-cycle enable, once per millisecond |
| supply_ok | input | 1 | Supply-above-threshold flag from the external comparator |
| pb_n | input | 1 | Push-button, active low, asynchronous |
| wd_strobe | input | 1 | Watchdog strobe, asynchronous |
| wd_sel | input | 2 | Timeout select: 00 short, 01 mid, 10/11 long |
| rst_hi_o | output | 1 | Active-high system reset |
| rst_lo_drive_o | output | 1 | Pull-down enable for the open-drain active-low reset |

## Verification
The bench builds the block with a hold of 8 ticks, a push-button filter of 3 ticks, and watchdog timeouts of 5, 10 and 15 ticks. It issues a tick every 8 clocks. With these values every window can be counted exactly, tick by tick, in a few hundred cycles. A hold window of 8 ticks is longer than the 5-tick timeout, so the bench can show that the watchdog is held cleared while reset is asserted. Every select level gets its own timeout measurement.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        SEL_LOW      = 2'b00,
        SEL_OPEN     = 2'b01,
        SEL_HIGH     = 2'b10,
        SEL_HIGH_ALT = 2'b11
    } wd_sel_e;

    // Timeout in ticks for one select level; both high codes give the long value.
    function automatic int unsigned wd_limit_ms(input wd_sel_e sel,
                                                input int unsigned lo,
                                                input int unsigned mid,
                                                input int unsigned hi);
        case (sel)
            SEL_LOW:  return lo;
            SEL_OPEN: return mid;
            default:  return hi;
        endcase
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int unsigned     W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;

endmodule

// File: rtl/supv_pb_filter.sv
module supv_pb_filter #(
    parameter int unsigned FILT_MS = 10,
    localparam int unsigned CW     = $clog2(FILT_MS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic          pb_s,      // synchronised, active low
    output logic          pressed_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] FULL = CW'(FILT_MS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pbf_t;

    pbf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pb_s) begin
            st_d.cnt = '0;
        end else if (ms_tick && (st_q.cnt != FULL)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pressed_o = !pb_s && (st_q.cnt == FULL);
    assign cnt_o     = st_q.cnt;

endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
    import supv_pkg::*;
#(
    parameter int unsigned SHORT_MS = 150,
    parameter int unsigned MID_MS   = 600,
    parameter int unsigned LONG_MS  = 1200,
    localparam int unsigned CW      = $clog2(max3(SHORT_MS, MID_MS, LONG_MS) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic          strobe_s,
    input  logic          hold_clr,
    input  logic [1:0]    sel,
    output logic          expire_o,
    output logic [CW-1:0] cnt_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          st_prev;
    } wd_t;

    wd_t           st_d, st_q;
    logic          fall;
    logic          at_end;
    logic [CW-1:0] last;

    always_comb begin
        last   = CW'(wd_limit_ms(wd_sel_e'(sel), SHORT_MS, MID_MS, LONG_MS) - 1);
        fall   = st_q.st_prev && !strobe_s;
        at_end = (st_q.cnt == last);
    end

    always_comb begin
        st_d         = st_q;
        st_d.st_prev = strobe_s;
        expire_o     = 1'b0;
        if (hold_clr || fall) begin
            st_d.cnt = '0;
        end else if (ms_tick) begin
            if (at_end) begin
                st_d.cnt = '0;
                expire_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, st_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/supv_hold.sv
module supv_hold #(
    parameter int unsigned HOLD_MS = 610,
    localparam int unsigned CW     = $clog2(HOLD_MS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic          trig,
    output logic          active_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] LAST = CW'(HOLD_MS - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && ms_tick) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    // Leaving the block's own reset starts the power-up hold window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign cnt_o    = st_q.cnt;

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
    import supv_pkg::*;
#(
    parameter int unsigned WD_SHORT_MS = 150,
    parameter int unsigned WD_MID_MS   = 600,
    parameter int unsigned WD_LONG_MS  = 1200,
    parameter int unsigned HOLD_MS     = 610,
    parameter int unsigned PB_FILT_MS  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       supply_ok,
    input  logic       pb_n,
    input  logic       wd_strobe,
    input  logic [1:0] wd_sel,
    output logic       rst_hi_o,
    output logic       rst_lo_drive_o
);

    localparam int unsigned HOLD_W = $clog2(HOLD_MS + 1);
    localparam int unsigned PB_W   = $clog2(PB_FILT_MS + 1);
    localparam int unsigned WD_W   = $clog2(max3(WD_SHORT_MS, WD_MID_MS, WD_LONG_MS) + 1);

    // Sync order: {supply, push-button, strobe}; button idles high.
    logic [2:0]        sync_out;
    logic              supply_s, pb_s, strobe_s;
    logic              pb_pressed;
    logic              wd_expire;
    logic              hold_active;
    logic              hold_trig;
    logic [HOLD_W-1:0] hold_cnt;
    logic [PB_W-1:0]   pb_cnt;
    logic [WD_W-1:0]   wd_cnt;

    supv_sync #(
        .W       (3),
        .RST_VAL (3'b010)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({supply_ok, pb_n, wd_strobe}),
        .dout  (sync_out)
    );

    assign supply_s = sync_out[2];
    assign pb_s     = sync_out[1];
    assign strobe_s = sync_out[0];

    supv_pb_filter #(
        .FILT_MS (PB_FILT_MS)
    ) i_pb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .pb_s      (pb_s),
        .pressed_o (pb_pressed),
        .cnt_o     (pb_cnt)
    );

    supv_watchdog #(
        .SHORT_MS (WD_SHORT_MS),
        .MID_MS   (WD_MID_MS),
        .LONG_MS  (WD_LONG_MS)
    ) i_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .strobe_s (strobe_s),
        .hold_clr (rst_hi_o),
        .sel      (wd_sel),
        .expire_o (wd_expire),
        .cnt_o    (wd_cnt)
    );

    assign hold_trig = !supply_s || pb_pressed || wd_expire;

    supv_hold #(
        .HOLD_MS (HOLD_MS)
    ) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .trig     (hold_trig),
        .active_o (hold_active),
        .cnt_o    (hold_cnt)
    );

    // The raw supply flag reaches the output without passing a flop.
    assign rst_hi_o       = hold_active || !supply_ok;
    assign rst_lo_drive_o = rst_hi_o;

endmodule

// File: rtl/supv_reset_ctrl_chk.sv
module supv_reset_ctrl_chk #(
    parameter int unsigned HOLD_MS    = 610,
    parameter int unsigned PB_FILT_MS = 10,
    parameter int unsigned HOLD_W     = 10,
    parameter int unsigned PB_W       = 4,
    parameter int unsigned WD_W       = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ms_tick,
    input logic              supply_ok,
    input logic              rst_hi_o,
    input logic              rst_lo_drive_o,
    input logic              hold_active,
    input logic [HOLD_W-1:0] hold_cnt,
    input logic [PB_W-1:0]   pb_cnt,
    input logic [WD_W-1:0]   wd_cnt,
    input logic              wd_expire
);

    a_r8_supply_low_forces_reset: assert property (
        @(posedge clk) disable iff (!rst_n) !supply_ok |-> rst_hi_o);

    a_r11_drive_tracks_reset: assert property (
        @(posedge clk) disable iff (!rst_n) rst_lo_drive_o == rst_hi_o);

    a_r1_release_on_tick: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(hold_active) |-> $past(ms_tick));

    a_r12_wd_cleared_in_reset: assert property (
        @(posedge clk) disable iff (!rst_n) rst_hi_o |=> (wd_cnt == '0));

    a_r6_pb_cnt_bound: assert property (
        @(posedge clk) disable iff (!rst_n) pb_cnt <= PB_W'(PB_FILT_MS));

    a_r10_expire_restarts_hold: assert property (
        @(posedge clk) disable iff (!rst_n) wd_expire |=> (hold_active && hold_cnt == '0));

    a_r9_hold_cnt_bound: assert property (
        @(posedge clk) disable iff (!rst_n) hold_cnt < HOLD_W'(HOLD_MS));

endmodule

bind supv_reset_ctrl supv_reset_ctrl_chk #(
    .HOLD_MS    (HOLD_MS),
    .PB_FILT_MS (PB_FILT_MS),
    .HOLD_W     (HOLD_W),
    .PB_W       (PB_W),
    .WD_W       (WD_W)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ms_tick        (ms_tick),
    .supply_ok      (supply_ok),
    .rst_hi_o       (rst_hi_o),
    .rst_lo_drive_o (rst_lo_drive_o),
    .hold_active    (hold_active),
    .hold_cnt       (hold_cnt),
    .pb_cnt         (pb_cnt),
    .wd_cnt         (wd_cnt),
    .wd_expire      (wd_expire)
);

// File: tb/test_supv_reset_ctrl.sv
`timescale 1ns/1ps
module test_supv_reset_ctrl;

    localparam int WD_S = 5;
    localparam int WD_M = 10;
    localparam int WD_L = 15;
    localparam int HOLD = 8;
    localparam int PBF  = 3;
    localparam int TDIV = 8;

    // Each entry: {select[1:0], expected timeout in ticks[5:0]}.
    localparam logic [7:0] WD_VEC [4] = '{
        {2'b00, 6'(WD_S)},
        {2'b01, 6'(WD_M)},
        {2'b10, 6'(WD_L)},
        {2'b11, 6'(WD_L)}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       supply_ok = 1'b1;
    logic       pb_n = 1'b1;
    logic       wd_strobe = 1'b0;
    logic [1:0] wd_sel = 2'b00;
    logic       rst_hi_o;
    logic       rst_lo_drive_o;
    logic       tick_en = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    supv_reset_ctrl #(
        .WD_SHORT_MS (WD_S),
        .WD_MID_MS   (WD_M),
        .WD_LONG_MS  (WD_L),
        .HOLD_MS     (HOLD),
        .PB_FILT_MS  (PBF)
    ) i_supv_reset_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .ms_tick        (ms_tick),
        .supply_ok      (supply_ok),
        .pb_n           (pb_n),
        .wd_strobe      (wd_strobe),
        .wd_sel         (wd_sel),
        .rst_hi_o       (rst_hi_o),
        .rst_lo_drive_o (rst_lo_drive_o)
    );

    // Tick generator: one pulse every TDIV clocks, changed on falling edges.
    initial begin
        int div;
        div = 0;
        forever begin
            @(negedge clk);
            if (tick_en) begin
                div     = (div + 1) % TDIV;
                ms_tick = (div == TDIV - 1);
            end else begin
                ms_tick = 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Returns on the falling edge right after a clock edge that carried a tick.
    task automatic after_tick();
        do @(posedge clk); while (!ms_tick);
        @(negedge clk);
    endtask

    // Counts the ticks until rst_hi_o reaches lvl; -1 if it never does.
    task automatic measure(input logic lvl, output int k);
        bit done;
        done = 1'b0;
        k = 0;
        for (int c = 0; c < 4000 && !done; c++) begin
            @(posedge clk);
            if (ms_tick) k++;
            #1;
            if (rst_hi_o == lvl) done = 1'b1;
        end
        if (!done) k = -1;
    endtask

    // Falling strobe edge, placed so that it clears the count before the next tick.
    task automatic kick();
        after_tick();
        wd_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wd_strobe = 1'b0;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: bench timed out, actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int k;
        int bad;

        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 reset held high", int'(rst_hi_o), 1);
        check("R11 drive during reset", int'(rst_lo_drive_o), 1);

        rst_n   = 1'b1;
        tick_en = 1'b1;
        measure(1'b0, k);
        check("R1 power-up hold ticks", k, HOLD);

        // R2 R3 R10: timeout per select level, then hold, then restart from zero
        for (int i = 0; i < 4; i++) begin
            wd_sel = WD_VEC[i][7:6];
            measure(1'b1, k);
            check((i == 3) ? "R3 select 11 timeout" : "R2 timeout for select", k, int'(WD_VEC[i][5:0]));
            measure(1'b0, k);
            check("R10 hold after watchdog", k, HOLD);
        end

        // R4: a rising edge does not clear the count
        wd_sel = 2'b00;
        after_tick();
        after_tick();
        wd_strobe = 1'b1;
        measure(1'b1, k);
        check("R4 rising edge leaves count", k, WD_S - 2);
        measure(1'b0, k);
        check("R10 hold after rise test", k, HOLD);

        // R4: a falling edge clears the count
        after_tick();
        after_tick();
        after_tick();
        wd_strobe = 1'b0;
        measure(1'b1, k);
        check("R4 falling edge clears count", k, WD_S);
        measure(1'b0, k);
        check("R10 hold after fall test", k, HOLD);

        // R5: regular strobes keep reset low
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            kick();
            after_tick();
            if (rst_hi_o) bad++;
            after_tick();
            if (rst_hi_o) bad++;
        end
        check("R5 strobed watchdog no reset", bad, 0);

        // R6: a short push-button press is ignored
        wd_sel = 2'b10;
        kick();
        bad = 0;
        pb_n = 1'b0;
        after_tick();
        if (rst_hi_o) bad++;
        after_tick();
        if (rst_hi_o) bad++;
        pb_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (rst_hi_o) bad++;
        end
        after_tick();
        if (rst_hi_o) bad++;
        check("R6 short press ignored", bad, 0);

        // R7: a long press asserts reset while held, then the hold window runs
        kick();
        pb_n = 1'b0;
        after_tick();
        after_tick();
        check("R7 not yet at filter limit", int'(rst_hi_o), 0);
        after_tick();
        @(negedge clk);
        @(negedge clk);
        check("R7 long press asserts", int'(rst_hi_o), 1);
        repeat (4) after_tick();
        check("R7 reset kept while held", int'(rst_hi_o), 1);
        pb_n = 1'b1;
        measure(1'b0, k);
        check("R7 hold after release", k, HOLD);

        // R8 R9 R11 R12: supply loss, recovery, watchdog held during reset
        wd_sel = 2'b00;
        after_tick();
        supply_ok = 1'b0;
        #1;
        check("R8 immediate reset on supply loss", int'(rst_hi_o), 1);
        check("R11 drive on supply loss", int'(rst_lo_drive_o), 1);
        repeat (6) after_tick();
        check("R8 reset kept while supply low", int'(rst_hi_o), 1);
        supply_ok = 1'b1;
        measure(1'b0, k);
        check("R9 hold after supply recovers", k, HOLD);
        check("R11 drive released", int'(rst_lo_drive_o), 0);
        measure(1'b1, k);
        check("R12 watchdog restarts from zero", k, WD_S);

        // R1: the block's own reset forces reset again
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset on block reset", int'(rst_hi_o), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule